// File: doc/BRIEF.md
# Bus Cycle Extension Controller

This block steps a processor bus transaction through its timing states and produces the control strobes the bus needs for it: active-low read, write, data-buffer enable and timing-state outputs, and an active-high ready. A transaction begins when the address strobe is seen low. The direction input, also active low, selects a read when low and a write when high. Without any extension a transaction lasts four CPU states, T1 through T4.

Each CPU state spans two cycles of `clk_i`: a first half and a second half. This lets the block sample some inputs at the end of a state and others in its middle. Three extension mechanisms can lengthen a transaction. All of them can be requested together, and each one is served in turn.
- A cycle hold (state TH) occurs before T2.
- A peripheral extension adds five states, TD0 to TD4, after T2.
- Wait states (TW) come from a continuous-wait input and from a 4-bit binary count held in a counter. The counter is reloaded every time continuous-wait is sampled low, so a transaction can be made longer or cut short.

Top module: `bus_ext_ctrl`

## Requirements
- R1: While `rst_ni` is low, and while no transaction is in progress, `rd_no`, `wr_no`, `dbe_no` and `tso_no` are high and `rdy_o` is high.
- R2: `ads_ni` is sampled only at the end of the second half of an idle state or of T4. A low sample makes the next state T1. `ddin_ni` is sampled at the same edge: low selects a read and high selects a write. `rd_no` and `wr_no` are never low together, and a low level on `ads_ni` at any other time is ignored.
- R3: A transaction with no extension occupies T1, T2, T3 and T4, two clock cycles each. A read drives `rd_no` low through T2 and T3; a write drives `wr_no` low through T2 and T3.
- R4: `cwait_ni` low at the end of T1 enters TH. The block stays in TH for every further state-end sample of `cwait_ni` that is low, then continues to T2. During TH the four strobes are high and `rdy_o` is low.
- R5: `per_ni` is sampled at the edge that enters T2. A low sample inserts TD0 to TD4 after T2. In such a transaction the read or write strobe is low only in TD1, TD2 and TD3 and in any TW between them.
- R6: `cwait_ni` and `wait_ni` are sampled for waits at the middle of T2 in a fast transaction, at the middle of TD2 in a peripheral transaction, and at the middle of each TW. Waits follow TD2 and precede TD3. Values on these inputs at any other point have no effect.
- R7: `wait_ni` is active low and binary weighted: bit i has weight 2^i. The first wait sample loads the counter, and each TW after a high `cwait_ni` sample consumes one count. For example, bits 0 and 2 low with `cwait_ni` high gives five TW states.
- R8: Every low `cwait_ni` wait sample adds one TW and reloads the counter from `wait_ni`. Counted TWs follow once `cwait_ni` is sampled high. `rdy_o` is low in every TW, and the block leaves TW at the end of the state in which `cwait_ni` was sampled high with the count at zero.
- R9: A low `cwait_ni` sample with all `wait_ni` bits high clears the remaining count. The transaction then ends after that one added TW, provided `cwait_ni` is sampled high at its middle.
- R10: When several extensions are requested in one transaction, they take effect in this order: hold first, then the peripheral states, then continuous waits, then counted waits.
- R11: `tso_no` falls on entry to T2 and rises on entry to T4. It is low across every TD and TW in between.
- R12: `dbe_no` goes low at the start of T2 for a write and at the middle of T2 for a read. In both cases it stays low until T4 begins.
- R13: `ads_ni` low at the end of T4 starts the next T1 with no idle state in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Half-state clock (two cycles per CPU state) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ads_ni | input | 1 | Address strobe, active low |
| ddin_ni | input | 1 | Direction, low = read, high = write |
| cwait_ni | input | 1 | Continuous wait / hold request, active low |
| per_ni | input | 1 | Peripheral transaction request, active low |
| wait_ni | input | WAIT_W | Binary wait count, active low, bit i weight 2^i |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| dbe_no | output | 1 | Data buffer enable, active low |
| tso_no | output | 1 | Timing-state output, low from T2 to T4 |
| rdy_o | output | 1 | Ready, low during hold and wait states |

## Verification
The bench drives noise on `cwait_ni`, `per_ni`, `wait_ni` and `ads_ni` at every half-state where they must not be sampled. A block that samples one half-state too early or too late would then insert or drop wait, hold or peripheral states, and the strobe trace would shift. A transaction that combines two continuous waits with a different reload count exposes a counter that sums the two counts or ignores the reload. The early-termination case exposes a counter that keeps counting down after a zero reload. A hold, peripheral and wait transaction on its own exposes any change in the order in which extensions are served. Back-to-back transactions catch a design that forces an idle state after T4. A read transaction catches a buffer enable that does not wait half a state before going low.

// File: rtl/bec_pkg.sv
package bec_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_T1, S_TH, S_T2,
    S_TD0, S_TD1, S_TD2, S_TD3, S_TD4,
    S_TW, S_T3, S_T4
  } bus_st_e;
endpackage

// File: rtl/bec_seq.sv
module bec_seq
  import bec_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    ads_ni,
  input  logic    ddin_ni,
  input  logic    cwait_ni,
  input  logic    per_ni,
  input  logic    ext_i,
  output bus_st_e st_o,
  output logic    hf_o,
  output logic    per_o,
  output logic    rd_o,
  output logic    smp_o,
  output logic    smp_init_o,
  output logic    dec_o
);
  bus_st_e st_q, st_d;
  logic hf_q, per_q, rd_q;
  logic wait_ph, start, to_t2;

  assign wait_ph = (st_q == S_T2 && !per_q) || st_q == S_TD2 || st_q == S_TW;
  assign smp_o      = !hf_q && wait_ph;
  assign smp_init_o = smp_o && st_q != S_TW;
  assign dec_o      = hf_q && wait_ph;
  assign start = hf_q && !ads_ni && (st_q == S_IDLE || st_q == S_T4);
  assign to_t2 = hf_q && cwait_ni && (st_q == S_T1 || st_q == S_TH);

  // state moves only at the end of the second half
  always_comb begin
    st_d = st_q;
    if (hf_q) begin
      unique case (st_q)
        S_IDLE, S_T4: st_d = ads_ni ? S_IDLE : S_T1;
        S_T1, S_TH:   st_d = cwait_ni ? S_T2 : S_TH;
        S_T2:         st_d = per_q ? S_TD0 : (ext_i ? S_TW : S_T3);
        S_TD0:        st_d = S_TD1;
        S_TD1:        st_d = S_TD2;
        S_TD2:        st_d = ext_i ? S_TW : S_TD3;
        S_TD3:        st_d = S_TD4;
        S_TD4:        st_d = S_T3;
        S_TW:         st_d = ext_i ? S_TW : (per_q ? S_TD3 : S_T3);
        S_T3:         st_d = S_T4;
        default:      st_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_IDLE;
      hf_q  <= 1'b0;
      per_q <= 1'b0;
      rd_q  <= 1'b0;
    end else begin
      hf_q <= ~hf_q;
      st_q <= st_d;
      if (start) rd_q  <= ~ddin_ni;
      if (to_t2) per_q <= ~per_ni;
    end
  end

  assign st_o  = st_q;
  assign hf_o  = hf_q;
  assign per_o = per_q;
  assign rd_o  = rd_q;

  AST_T1_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> st_q == S_T1); // R2
  AST_HALF_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hf_q |=> st_q == $past(st_q)); // R3
  AST_HF_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hf_q |=> !hf_q); // R3
  AST_TD_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_TD4 && hf_q) |=> st_q == S_T3); // R5
  AST_HOLD_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_TH && hf_q && cwait_ni) |=> st_q == S_T2); // R4
endmodule

// File: rtl/bec_wait_cnt.sv
module bec_wait_cnt #(
  parameter int WAIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_i,
  input  logic              smp_init_i,
  input  logic              dec_i,
  input  logic              cwait_ni,
  input  logic [WAIT_W-1:0] wait_ni,
  output logic              ext_o
);
  logic [WAIT_W-1:0] cnt_q, wait_val;
  logic cw_q, cnt_nz;

  assign wait_val = ~wait_ni;
  assign cnt_nz   = cnt_q != '0;
  assign ext_o    = cw_q || cnt_nz;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cw_q  <= 1'b0;
    end else if (smp_i) begin
      cw_q <= ~cwait_ni;
      // first sample always loads; later ones only on a low cwait
      if (smp_init_i || !cwait_ni) cnt_q <= wait_val;
    end else if (dec_i && !cw_q && cnt_nz) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_CNT_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !cw_q && cnt_nz) |=> cnt_q == $past(cnt_q) - 1'b1); // R7
  AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_i && !cwait_ni) |=> (ext_o && cnt_q == $past(wait_val))); // R8
  AST_EARLY_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_i && !cwait_ni && wait_ni == '1) |=> !cnt_nz); // R9
endmodule

// File: rtl/bec_strobes.sv
module bec_strobes
  import bec_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  bus_st_e st_i,
  input  logic    hf_i,
  input  logic    per_i,
  input  logic    rd_i,
  output logic    rd_no,
  output logic    wr_no,
  output logic    dbe_no,
  output logic    tso_no,
  output logic    rdy_o
);
  logic in_data, act, dbe_on;

  assign in_data = st_i inside {S_T2, S_TD0, S_TD1, S_TD2, S_TD3, S_TD4, S_TW, S_T3};
  // peripheral transactions narrow the strobe for extra setup and hold
  assign act = per_i ? (st_i inside {S_TD1, S_TD2, S_TD3, S_TW})
                     : (st_i inside {S_T2, S_TW, S_T3});
  assign dbe_on = in_data && !(st_i == S_T2 && rd_i && !hf_i);

  assign rd_no  = !(act && rd_i);
  assign wr_no  = !(act && !rd_i);
  assign dbe_no = !dbe_on;
  assign tso_no = !in_data;
  assign rdy_o  = !(st_i == S_TW || st_i == S_TH);

  AST_RW_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_no && !wr_no)); // R2
  AST_HOLD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_i == S_TH |-> (rd_no && wr_no && dbe_no && tso_no && !rdy_o)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_i == S_IDLE |-> (rd_no && wr_no && dbe_no && tso_no && rdy_o)); // R1
endmodule

// File: rtl/bus_ext_ctrl.sv
module bus_ext_ctrl
  import bec_pkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ads_ni,
  input  logic              ddin_ni,
  input  logic              cwait_ni,
  input  logic              per_ni,
  input  logic [WAIT_W-1:0] wait_ni,
  output logic              rd_no,
  output logic              wr_no,
  output logic              dbe_no,
  output logic              tso_no,
  output logic              rdy_o
);
  bus_st_e st;
  logic hf, per, rd, smp, smp_init, dec, ext;

  bec_seq u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .ads_ni(ads_ni), .ddin_ni(ddin_ni),
    .cwait_ni(cwait_ni), .per_ni(per_ni), .ext_i(ext),
    .st_o(st), .hf_o(hf), .per_o(per), .rd_o(rd),
    .smp_o(smp), .smp_init_o(smp_init), .dec_o(dec)
  );

  bec_wait_cnt #(.WAIT_W(WAIT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .smp_i(smp), .smp_init_i(smp_init),
    .dec_i(dec), .cwait_ni(cwait_ni), .wait_ni(wait_ni), .ext_o(ext)
  );

  bec_strobes u_strb (
    .clk_i(clk_i), .rst_ni(rst_ni), .st_i(st), .hf_i(hf), .per_i(per), .rd_i(rd),
    .rd_no(rd_no), .wr_no(wr_no), .dbe_no(dbe_no), .tso_no(tso_no), .rdy_o(rdy_o)
  );
endmodule

// File: tb/bus_ext_ctrl_tb_top.sv
module bus_ext_ctrl_tb_top;
  localparam int B_IDLE = 0, B_T1 = 1, B_TH = 2, B_T2 = 3, B_TD0 = 4,
                 B_TW = 9, B_T3 = 10, B_T4 = 11;

  typedef struct {
    int         st;
    bit         hf;
    bit         ads, ddin, cw, per;
    logic [3:0] wt;
    logic [4:0] exp;
    string      tag;
  } rec_t;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic ads_ni = 1'b1, ddin_ni = 1'b1, cwait_ni = 1'b1, per_ni = 1'b1;
  logic [3:0] wait_ni = 4'hF;
  logic rd_no, wr_no, dbe_no, tso_no, rdy_o;

  int tests = 0, fails = 0;
  bit done = 1'b0;
  rec_t q[$];
  bit ph_next = 1'b0;

  always #10 clk_i = ~clk_i;

  bus_ext_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .ads_ni(ads_ni), .ddin_ni(ddin_ni),
    .cwait_ni(cwait_ni), .per_ni(per_ni), .wait_ni(wait_ni),
    .rd_no(rd_no), .wr_no(wr_no), .dbe_no(dbe_no), .tso_no(tso_no), .rdy_o(rdy_o)
  );

  // expected {rd, wr, dbe, tso, rdy} for one half-state
  function automatic logic [4:0] exp_out(int st, bit hf, bit p, bit r);
    bit tw = (st == B_TW);
    bit td = (st >= B_TD0 && st <= B_TD0 + 4);
    bit in_data = (st == B_T2) || td || tw || (st == B_T3);
    bit act = p ? (tw || (st >= B_TD0 + 1 && st <= B_TD0 + 3))
                : ((st == B_T2) || tw || (st == B_T3));
    bit dbe_on = in_data && !(st == B_T2 && r && !hf);
    return {!(act && r), !(act && !r), !dbe_on, !in_data, !(tw || st == B_TH)};
  endfunction

  // defaults put noise on inputs at points that must not be sampled (R6)
  task automatic push(int st, bit p, bit r, string tag);
    rec_t e;
    e.st   = st;
    e.hf   = ph_next;
    e.ads  = ph_next && (st == B_IDLE || st == B_T4);
    e.ddin = ph_next;
    e.cw   = !ph_next;
    e.per  = 1'b0;
    e.wt   = 4'h0;
    e.exp  = exp_out(st, ph_next, p, r);
    e.tag  = tag;
    q.push_back(e);
    ph_next = !ph_next;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) push(B_IDLE, 1'b0, 1'b0, "R1");
  endtask

  task automatic gen_cycle(bit r, int nhold, bit p, logic [15:0] pat,
                           int wv0, int wvk, string tag);
    int k, cnt;
    bit low;
    if (q.size() > 0 && q[q.size()-1].st == B_T4 && q[q.size()-1].hf) begin
      q[q.size()-1].ads  = 1'b0;   // R13 back-to-back
      q[q.size()-1].ddin = !r;
    end else begin
      if (!ph_next) push(B_IDLE, 1'b0, 1'b0, tag);
      push(B_IDLE, 1'b0, 1'b0, tag);
      q[q.size()-1].ads  = 1'b0;
      q[q.size()-1].ddin = !r;
    end
    push(B_T1, p, r, tag);
    push(B_T1, p, r, tag);
    q[q.size()-1].cw = !(nhold > 0);
    if (nhold == 0) q[q.size()-1].per = !p;
    for (int h = 0; h < nhold; h++) begin
      push(B_TH, p, r, tag);
      push(B_TH, p, r, tag);
      q[q.size()-1].cw = !(h + 1 < nhold);
      if (h + 1 == nhold) q[q.size()-1].per = !p;
    end
    push(B_T2, p, r, tag);
    if (!p) begin
      q[q.size()-1].cw = !pat[0];
      q[q.size()-1].wt = ~wv0[3:0];
    end
    push(B_T2, p, r, tag);
    if (p) begin
      for (int d = 0; d < 2; d++) begin
        push(B_TD0 + d, p, r, tag);
        push(B_TD0 + d, p, r, tag);
      end
      push(B_TD0 + 2, p, r, tag);
      q[q.size()-1].cw = !pat[0];
      q[q.size()-1].wt = ~wv0[3:0];
      push(B_TD0 + 2, p, r, tag);
    end
    k = 0; low = pat[0]; cnt = wv0;
    while (low || cnt > 0) begin
      if (!low) cnt--;
      k++;
      push(B_TW, p, r, tag);
      q[q.size()-1].cw = !pat[k];
      q[q.size()-1].wt = ~wvk[3:0];
      push(B_TW, p, r, tag);
      low = pat[k];
      if (low) cnt = wvk;
    end
    if (p) begin
      for (int d = 3; d < 5; d++) begin
        push(B_TD0 + d, p, r, tag);
        push(B_TD0 + d, p, r, tag);
      end
    end
    push(B_T3, p, r, tag); push(B_T3, p, r, tag);
    push(B_T4, p, r, tag); push(B_T4, p, r, tag);
  endtask

  task automatic check_rec(rec_t e);
    logic [4:0] act;
    string t;
    act = {rd_no, wr_no, dbe_no, tso_no, rdy_o};
    tests++;
    if (act !== e.exp) begin
      fails++;
      t = e.tag;
      if (act[1] !== e.exp[1]) t = {t, "/R11"};
      if (act[2] !== e.exp[2]) t = {t, "/R12"};
      $display("FAIL %s state=%0d half=%0d {rd,wr,dbe,tso,rdy} actual=%b expected=%b",
               t, e.st, e.hf, act, e.exp);
    end
  endtask

  initial begin
    rec_t rst_rec;
    idle(3);
    gen_cycle(1'b1, 0, 1'b0, 16'h0, 0, 0, "R2");        // plain read
    idle(2);
    gen_cycle(1'b0, 0, 1'b0, 16'h0, 0, 0, "R3");        // plain write
    idle(1);
    gen_cycle(1'b0, 0, 1'b0, 16'h0, 5, 0, "R7");        // weights 1+4
    gen_cycle(1'b1, 0, 1'b0, 16'h0, 15, 0, "R7");
    idle(2);
    gen_cycle(1'b1, 0, 1'b0, 16'h0, 1, 0, "R7");
    idle(3);
    gen_cycle(1'b1, 0, 1'b0, 16'h0003, 3, 10, "R8");    // 2 continuous + reload 10
    idle(2);
    gen_cycle(1'b0, 0, 1'b0, 16'h0010, 11, 0, "R9");    // zero reload mid-count
    idle(2);
    gen_cycle(1'b1, 3, 1'b0, 16'h0, 0, 0, "R4");        // three hold states
    idle(2);
    gen_cycle(1'b0, 0, 1'b1, 16'h0, 0, 0, "R5");        // peripheral write
    idle(2);
    gen_cycle(1'b0, 0, 1'b1, 16'h0001, 5, 5, "R6");     // peripheral + waits after TD2
    idle(2);
    gen_cycle(1'b1, 2, 1'b1, 16'h0001, 2, 2, "R10");    // hold, peripheral, waits
    gen_cycle(1'b1, 0, 1'b0, 16'h0, 0, 0, "R13");
    gen_cycle(1'b0, 0, 1'b0, 16'h0, 2, 0, "R13");
    idle(4);

    repeat (3) @(negedge clk_i);
    rst_rec.exp = 5'b11111; rst_rec.tag = "R1"; rst_rec.st = B_IDLE; rst_rec.hf = 1'b0;
    check_rec(rst_rec);                                 // R1 during reset
    rst_ni = 1'b1;
    foreach (q[i]) begin
      check_rec(q[i]);
      ads_ni   = q[i].ads;
      ddin_ni  = q[i].ddin;
      cwait_ni = q[i].cw;
      per_ni   = q[i].per;
      wait_ni  = q[i].wt;
      @(negedge clk_i);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule